// File: doc/BRIEF.md
# Sequential Read-Ahead Line Buffer

This block sits on the read path between a processor and main memory, beside the level-one and level-two caches rather than inside them. It holds a few recently fetched memory lines. A read that finds its line resident is answered from the buffer. A read that misses goes to memory. Once the demand line has come back, the block may fetch the line that follows it in the background, on the chance that the processor reads it next.

Software chooses where read-ahead is allowed, using an address window and a mode bit that limits it to instruction fetches. The contents can be discarded only all at once. That happens through a dedicated pulse input, or automatically when the processor signals a data-cache invalidate by address and automatic clearing is switched on. An invalidate that names a cache set and way rather than an address never clears the buffer. Read-ahead never leaves the current 4 KB page.

Top module: `readahead_buf`

## Requirements
- R1: A read that finds its line resident is answered on the cycle after it is accepted, with no memory request.
- R2: On a miss, the first memory request is for the line-aligned demand address and the returned word goes to the processor. Only after that response is at most one further request made, for the line that follows. Lines are 32 bytes, and each memory request carries a line-aligned address.
- R3: No read-ahead is issued when the following line lies in another 4 KB page, meaning the demand line is at offset 0xFE0 of its page.
- R4: A pulse on `flushPulse` discards every resident line. Until then a resident line keeps being returned even if memory has changed.
- R5: With register 0 bit 2 set, a cache maintenance strobe with `cacheOpByAddr` high discards every resident line.
- R6: A strobe with `cacheOpByAddr` low never clears the buffer. A strobe with `cacheOpByAddr` high has no effect while register 0 bit 2 is clear.
- R7: With register 0 bit 1 set, reads with `cpuReqInstr` low go straight to memory, even when the line is resident, and they install nothing and start no read-ahead. Instruction reads still use the buffer.
- R8: Only addresses A with base ≤ A < limit (registers 1 and 2) are buffered. Other reads go straight to memory and install nothing. No read-ahead is made for a following line outside the window.
- R9: With register 0 bit 0 clear, every read goes to memory, and no read-ahead is issued.
- R10: A flush that arrives while a line fetch is outstanding prevents that line from being installed.
- R11: The buffer holds four lines and replaces them in round-robin order of installation.
- R12: No read-ahead is issued when the following line is already resident.
- R13: Register 0 holds enable (bit 0), instruction-only mode (bit 1) and automatic clearing (bit 2). Register 1 holds the window base and register 2 the window limit. All of them read back what was written, and all reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReqValid | input | 1 | Processor read request |
| cpuReqReady | output | 1 | Block can accept a read |
| cpuReqAddr | input | ADDR_W | Byte address of the read |
| cpuReqInstr | input | 1 | Read is an instruction fetch |
| cpuRespValid | output | 1 | Read data valid, one-cycle pulse |
| cpuRespData | output | DATA_W | Read data word |
| memReqValid | output | 1 | Memory line read request |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Line-aligned memory address |
| memRespValid | input | 1 | Memory line returned |
| memRespData | input | LINE_BYTES*8 | Returned line, word 0 in the low bits |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register index |
| regWrData | input | ADDR_W | Register write value |
| regRdData | output | ADDR_W | Selected register value |
| flushPulse | input | 1 | Discard all resident lines |
| cacheOpValid | input | 1 | Data-cache invalidate performed |
| cacheOpByAddr | input | 1 | Invalidate was address-based (1) or index-based (0) |

## Verification
The bench targets the page edge. A design that ignores the 4 KB limit would issue a read-ahead into the next page for a demand line at offset 0xFE0. It also targets a read-ahead line that is already resident: a design that skips that check would issue a second memory request. It pulses a flush while the read-ahead is still in flight and then reads the prefetched line. A design that installs that returning line would answer the read without going to memory. The bench also separates the two kinds of invalidate and the data-versus-instruction mode, where a wrong design either keeps stale lines or serves data reads that should have bypassed the buffer. Finally, it fills all four entries and checks that the two oldest are the ones evicted.

// File: rtl/rab_pkg.sv
package rab_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DWAIT,
    ST_PREQ,
    ST_PWAIT
  } rab_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic flushAll;
    logic install;
    logic respHit;
    logic respMem;
  } rab_strb_t;

  typedef struct packed {
    logic enable;
    logic instrOnly;
    logic autoFlush;
  } rab_mode_t;

endpackage

// File: rtl/rab_regs.sv
module rab_regs import rab_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  output rab_mode_t         mode,
  output logic [ADDR_W-1:0] winLo,
  output logic [ADDR_W-1:0] winHi
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode  <= '0;
      winLo <= '0;
      winHi <= '0;
    end else if (regWrEn) begin
      unique case (regSel)
        2'd0: begin
          mode.enable    <= regWrData[0];
          mode.instrOnly <= regWrData[1];
          mode.autoFlush <= regWrData[2];
        end
        2'd1: winLo <= regWrData;
        2'd2: winHi <= regWrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (regSel)
      2'd0:    regRdData = {{(ADDR_W-3){1'b0}}, mode.autoFlush, mode.instrOnly, mode.enable};
      2'd1:    regRdData = winLo;
      2'd2:    regRdData = winHi;
      default: regRdData = '0;
    endcase
  end

endmodule

// File: rtl/rab_ctrl.sv
module rab_ctrl import rab_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 5,
  parameter int WORD_BITS = 2,
  parameter int PAGE_BITS = 12,
  localparam int TAG_W    = ADDR_W - LINE_BITS,
  localparam int IDX_W    = LINE_BITS - WORD_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  rab_mode_t         mode,
  input  logic [ADDR_W-1:0] winLo,
  input  logic [ADDR_W-1:0] winHi,
  input  logic              cpuReqValid,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic              cpuReqInstr,
  output logic              cpuReqReady,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRespValid,
  input  logic              flushPulse,
  input  logic              cacheOpValid,
  input  logic              cacheOpByAddr,
  input  logic              hitAny,
  output rab_strb_t         strb,
  output logic [TAG_W-1:0]  lookTag,
  output logic [TAG_W-1:0]  instTag,
  output logic [IDX_W-1:0]  wordIdx
);

  rab_state_t stateQ;
  logic [ADDR_W-1:WORD_BITS] curWordQ;
  logic curEligQ;
  logic killQ;

  logic [TAG_W-1:0] curTag, nextTag, reqTag;
  logic [ADDR_W-1:0] nextAddr;
  logic reqElig, doFlush, lastInPage, pfOk, isIdle;

  function automatic logic inWindow(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] lo,
                                    input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a < hi);
  endfunction

  assign isIdle     = (stateQ == ST_IDLE);
  assign reqTag     = cpuReqAddr[ADDR_W-1:LINE_BITS];
  assign curTag     = curWordQ[ADDR_W-1:LINE_BITS];
  assign nextTag    = curTag + 1'b1;
  assign nextAddr   = {nextTag, {LINE_BITS{1'b0}}};
  assign lastInPage = &curWordQ[PAGE_BITS-1:LINE_BITS];

  assign reqElig = mode.enable && inWindow(cpuReqAddr, winLo, winHi) &&
                   (!mode.instrOnly || cpuReqInstr);
  assign doFlush = flushPulse || (cacheOpValid && cacheOpByAddr && mode.autoFlush);

  // in DWAIT the lookup port probes the following line
  assign lookTag = isIdle ? reqTag : nextTag;
  assign wordIdx = isIdle ? cpuReqAddr[LINE_BITS-1:WORD_BITS]
                          : curWordQ[LINE_BITS-1:WORD_BITS];
  assign instTag = (stateQ == ST_PWAIT) ? nextTag : curTag;

  assign pfOk = curEligQ && !lastInPage && inWindow(nextAddr, winLo, winHi) && !hitAny;

  assign cpuReqReady = isIdle;
  assign memReqValid = (stateQ == ST_DREQ) || (stateQ == ST_PREQ);
  assign memReqAddr  = {(stateQ == ST_PREQ) ? nextTag : curTag, {LINE_BITS{1'b0}}};

  always_comb begin
    strb          = '0;
    strb.flushAll = doFlush;
    strb.respHit  = isIdle && cpuReqValid && reqElig && hitAny;
    strb.respMem  = (stateQ == ST_DWAIT) && memRespValid;
    strb.install  = memRespValid && !killQ && !doFlush &&
                    (((stateQ == ST_DWAIT) && curEligQ) || (stateQ == ST_PWAIT));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      curWordQ <= '0;
      curEligQ <= 1'b0;
      killQ    <= 1'b0;
    end else begin
      if (doFlush && !isIdle) killQ <= 1'b1;
      unique case (stateQ)
        ST_IDLE: if (cpuReqValid && !(reqElig && hitAny)) begin
          curWordQ <= cpuReqAddr[ADDR_W-1:WORD_BITS];
          curEligQ <= reqElig;
          killQ    <= 1'b0;
          stateQ   <= ST_DREQ;
        end
        ST_DREQ:  if (memReqReady) stateQ <= ST_DWAIT;
        ST_DWAIT: if (memRespValid) begin
          if (pfOk) begin
            killQ  <= 1'b0;
            stateQ <= ST_PREQ;
          end else begin
            stateQ <= ST_IDLE;
          end
        end
        ST_PREQ:  if (memReqReady) stateQ <= ST_PWAIT;
        ST_PWAIT: if (memRespValid) stateQ <= ST_IDLE;
        default:  stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rab_store.sv
module rab_store import rab_pkg::*; #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 27,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 3,
  localparam int WORDS  = 1 << IDX_W,
  localparam int LINE_W = DATA_W * WORDS,
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rab_strb_t         strb,
  input  logic [TAG_W-1:0]  lookTag,
  input  logic [TAG_W-1:0]  instTag,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [LINE_W-1:0] memLine,
  output logic              hitAny,
  output logic              respValid,
  output logic [DATA_W-1:0] respData
);

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ  [ENTRIES];
  logic [LINE_W-1:0]  lineQ [ENTRIES];
  logic [PTR_W-1:0]   rrPtrQ;
  logic [ENTRIES-1:0] matchVec;
  logic [LINE_W-1:0]  hitLine;
  logic [DATA_W-1:0]  hitWord, memWord;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_match
    assign matchVec[e] = validQ[e] && (tagQ[e] == lookTag);
  end

  assign hitAny = |matchVec;

  always_comb begin
    hitLine = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (matchVec[e]) hitLine = hitLine | lineQ[e];
  end

  always_comb begin
    hitWord = '0;
    memWord = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (wordIdx == IDX_W'(w)) begin
        hitWord = hitLine[w*DATA_W +: DATA_W];
        memWord = memLine[w*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      rrPtrQ <= '0;
    end else if (strb.flushAll) begin
      validQ <= '0;
    end else if (strb.install) begin
      validQ[rrPtrQ] <= 1'b1;
      if (rrPtrQ == PTR_W'(ENTRIES - 1)) rrPtrQ <= '0;
      else                               rrPtrQ <= rrPtrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (strb.install && !strb.flushAll && rrPtrQ == PTR_W'(e)) begin
        tagQ[e]  <= instTag;
        lineQ[e] <= memLine;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respData  <= '0;
    end else begin
      respValid <= strb.respHit || strb.respMem;
      if (strb.respHit)      respData <= hitWord;
      else if (strb.respMem) respData <= memWord;
    end
  end

endmodule

// File: rtl/readahead_buf.sv
module readahead_buf import rab_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int ENTRIES    = 4,
  parameter int PAGE_BYTES = 4096,
  localparam int LINE_BITS = $clog2(LINE_BYTES),
  localparam int WORD_BITS = $clog2(DATA_W / 8),
  localparam int PAGE_BITS = $clog2(PAGE_BYTES),
  localparam int TAG_W     = ADDR_W - LINE_BITS,
  localparam int IDX_W     = LINE_BITS - WORD_BITS,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReqValid,
  output logic              cpuReqReady,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic              cpuReqInstr,
  output logic              cpuRespValid,
  output logic [DATA_W-1:0] cpuRespData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRespValid,
  input  logic [LINE_W-1:0] memRespData,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic              flushPulse,
  input  logic              cacheOpValid,
  input  logic              cacheOpByAddr
);

  rab_mode_t         mode;
  logic [ADDR_W-1:0] winLo, winHi;
  rab_strb_t         strb;
  logic [TAG_W-1:0]  lookTag, instTag;
  logic [IDX_W-1:0]  wordIdx;
  logic              hitAny;

  rab_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .mode(mode),
    .winLo(winLo), .winHi(winHi)
  );

  rab_ctrl #(
    .ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS),
    .WORD_BITS(WORD_BITS), .PAGE_BITS(PAGE_BITS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .mode(mode), .winLo(winLo), .winHi(winHi),
    .cpuReqValid(cpuReqValid), .cpuReqAddr(cpuReqAddr),
    .cpuReqInstr(cpuReqInstr), .cpuReqReady(cpuReqReady),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRespValid(memRespValid),
    .flushPulse(flushPulse), .cacheOpValid(cacheOpValid),
    .cacheOpByAddr(cacheOpByAddr), .hitAny(hitAny), .strb(strb),
    .lookTag(lookTag), .instTag(instTag), .wordIdx(wordIdx)
  );

  rab_store #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) store_i (
    .clk(clk), .rstN(rstN), .strb(strb), .lookTag(lookTag),
    .instTag(instTag), .wordIdx(wordIdx), .memLine(memRespData),
    .hitAny(hitAny), .respValid(cpuRespValid), .respData(cpuRespData)
  );

endmodule

// File: rtl/rab_checker.sv
module rab_checker #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 5,
  parameter int PAGE_BITS = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReqValid,
  input logic              cpuReqReady,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              flushPulse,
  input logic              cacheOpValid,
  input logic              cacheOpByAddr,
  input logic              flushAll,
  input logic              hitAny
);

  // a memory request with no processor read accepted since the previous one is a read-ahead
  logic              cpuSinceMemQ;
  logic [ADDR_W-1:0] lastMemAddrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuSinceMemQ <= 1'b0;
      lastMemAddrQ <= '0;
    end else begin
      if (cpuReqValid && cpuReqReady) cpuSinceMemQ <= 1'b1;
      if (memReqValid && memReqReady) begin
        cpuSinceMemQ <= 1'b0;
        lastMemAddrQ <= memReqAddr;
      end
    end
  end

  p_line_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[LINE_BITS-1:0] == '0));

  p_single_txn_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !cpuReqReady);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  p_pf_same_page_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !cpuSinceMemQ) |->
      ((memReqAddr == lastMemAddrQ + ADDR_W'(1 << LINE_BITS)) &&
       (memReqAddr[ADDR_W-1:PAGE_BITS] == lastMemAddrQ[ADDR_W-1:PAGE_BITS])));

  p_flush_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> !hitAny);

  p_index_op_no_flush_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cacheOpValid && !cacheOpByAddr && !flushPulse) |-> !flushAll);

endmodule

bind readahead_buf rab_checker #(
  .ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS), .PAGE_BITS(PAGE_BITS)
) chk_i (
  .clk(clk), .rstN(rstN), .cpuReqValid(cpuReqValid), .cpuReqReady(cpuReqReady),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
  .flushPulse(flushPulse), .cacheOpValid(cacheOpValid),
  .cacheOpByAddr(cacheOpByAddr), .flushAll(strb.flushAll), .hitAny(hitAny)
);

// File: tb/readahead_buf_tb_top.sv
`timescale 1ns/1ps
module readahead_buf_tb_top;

  localparam int LINE_W = 256;
  localparam int NVEC   = 11;

  // table: address, expected memory requests (0 hit, 1 miss only, 2 miss + read-ahead)
  localparam logic [31:0] VEC_ADDR [NVEC] = '{
    32'h1000_0104, 32'h1000_0108, 32'h1000_013C, 32'h1000_0FE4,
    32'h1000_0FE0, 32'h2000_0000, 32'h2000_0000, 32'h1000_7FC4,
    32'h1000_7FE0, 32'h1000_7FE0, 32'h1000_0100 };
  localparam int VEC_REQS [NVEC] = '{2, 0, 0, 1, 0, 1, 1, 1, 1, 1, 0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReqValid = 1'b0, cpuReqInstr = 1'b0;
  logic [31:0] cpuReqAddr = '0;
  logic cpuReqReady, cpuRespValid, memReqValid;
  logic [31:0] cpuRespData, memReqAddr, regRdData;
  logic memReqReady = 1'b1;
  logic memRespValid = 1'b0;
  logic [LINE_W-1:0] memRespData = '0;
  logic regWrEn = 1'b0;
  logic [1:0] regSel = '0;
  logic [31:0] regWrData = '0;
  logic flushPulse = 1'b0, cacheOpValid = 1'b0, cacheOpByAddr = 1'b0;

  int checkCount = 0;
  int failCount = 0;
  int reqCount = 0;
  logic [31:0] reqLog [64];
  logic [7:0] memGen = 8'd0;
  logic [31:0] pendAddr = '0;
  int pendCnt = 0;

  always #4 clk = ~clk;

  readahead_buf dut_i (
    .clk(clk), .rstN(rstN), .cpuReqValid(cpuReqValid), .cpuReqReady(cpuReqReady),
    .cpuReqAddr(cpuReqAddr), .cpuReqInstr(cpuReqInstr), .cpuRespValid(cpuRespValid),
    .cpuRespData(cpuRespData), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRespValid(memRespValid), .memRespData(memRespData),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .flushPulse(flushPulse), .cacheOpValid(cacheOpValid), .cacheOpByAddr(cacheOpByAddr)
  );

  function automatic logic [31:0] mkWord(input logic [31:0] a, input logic [7:0] g);
    return {g, a[23:2], 2'b00};
  endfunction

  function automatic logic [LINE_W-1:0] mkLine(input logic [31:0] la, input logic [7:0] g);
    logic [LINE_W-1:0] l;
    for (int w = 0; w < 8; w++) l[w*32 +: 32] = mkWord(la + 32'(4 * w), g);
    return l;
  endfunction

  // memory model: accepts every request, answers three cycles later
  always @(posedge clk) begin
    memRespValid <= 1'b0;
    if (pendCnt > 0) begin
      pendCnt <= pendCnt - 1;
      if (pendCnt == 1) begin
        memRespValid <= 1'b1;
        memRespData  <= mkLine(pendAddr, memGen);
      end
    end
    if (memReqValid && memReqReady) begin
      pendAddr <= memReqAddr;
      pendCnt  <= 3;
      reqLog[reqCount % 64] <= memReqAddr;
      reqCount <= reqCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] val);
    regWrEn = 1'b1; regSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulseFlush();
    flushPulse = 1'b1;
    @(negedge clk);
    flushPulse = 1'b0;
  endtask

  task automatic cacheOp(input logic byAddr);
    cacheOpValid = 1'b1; cacheOpByAddr = byAddr;
    @(negedge clk);
    cacheOpValid = 1'b0; cacheOpByAddr = 1'b0;
  endtask

  // called at a falling edge with the block idle; returns at a falling edge idle again
  task automatic cpuRead(input logic [31:0] a, input logic instr,
                         output logic [31:0] data, output int nReq, output int lat,
                         output int firstIdx);
    int start;
    start = reqCount;
    firstIdx = start;
    cpuReqValid = 1'b1; cpuReqAddr = a; cpuReqInstr = instr;
    @(posedge clk);
    @(negedge clk);
    cpuReqValid = 1'b0;
    lat = 1;
    while (!cpuRespValid) begin @(negedge clk); lat++; end
    data = cpuRespData;
    while (!cpuReqReady) @(negedge clk);
    nReq = reqCount - start;
  endtask

  task automatic doRead(input logic [31:0] a, input logic instr, input int expReqs,
                        input logic [7:0] expGen, input string req);
    logic [31:0] d;
    int n, lat, fi;
    logic [31:0] line;
    line = {a[31:5], 5'd0};
    cpuRead(a, instr, d, n, lat, fi);
    check(n == expReqs, req, 32'(n), 32'(expReqs));
    check(d == mkWord(a, expGen), req, d, mkWord(a, expGen));
    if (expReqs == 0) check(lat == 1, {req, " hit latency"}, 32'(lat), 32'd1);
    if (expReqs >= 1) check(reqLog[fi % 64] == line, {req, " demand addr"}, reqLog[fi % 64], line);
    if (expReqs == 2)
      check(reqLog[(fi + 1) % 64] == line + 32'd32, {req, " read-ahead addr"},
            reqLog[(fi + 1) % 64], line + 32'd32);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state and register map (R13)
    check(cpuReqReady == 1'b1, "R13 reset ready", 32'(cpuReqReady), 32'd1);
    check(memReqValid == 1'b0 && cpuRespValid == 1'b0, "R13 reset idle outputs",
          32'({memReqValid, cpuRespValid}), 32'd0);
    regSel = 2'd0; #1;
    check(regRdData == 32'd0, "R13 reset mode reg", regRdData, 32'd0);
    regSel = 2'd2; #1;
    check(regRdData == 32'd0, "R13 reset limit reg", regRdData, 32'd0);
    @(negedge clk);
    regWrite(2'd0, 32'hFFFF_FFFF);
    regSel = 2'd0; #1;
    check(regRdData == 32'h7, "R13 mode readback", regRdData, 32'h7);
    @(negedge clk);
    regWrite(2'd1, 32'h1000_0000);
    regWrite(2'd2, 32'h1000_7FE0);
    regWrite(2'd0, 32'h1);
    regSel = 2'd1; #1;
    check(regRdData == 32'h1000_0000, "R13 base readback", regRdData, 32'h1000_0000);
    regSel = 2'd2; #1;
    check(regRdData == 32'h1000_7FE0, "R13 limit readback", regRdData, 32'h1000_7FE0);
    @(negedge clk);

    // table walk: R1 R2 R3 R8
    for (int i = 0; i < NVEC; i++)
      doRead(VEC_ADDR[i], 1'b0, VEC_REQS[i], 8'd0, $sformatf("R1/R2/R3/R8 vec%0d", i));

    // R11 round robin: slots hold 100,120,FE0,7FC0; next two installs replace 100 and 120
    doRead(32'h1000_2000, 1'b0, 2, 8'd0, "R11 fill");
    doRead(32'h1000_0FE0, 1'b0, 0, 8'd0, "R11 third entry kept");
    doRead(32'h1000_7FC0, 1'b0, 0, 8'd0, "R11 fourth entry kept");
    doRead(32'h1000_0100, 1'b0, 2, 8'd0, "R11 oldest evicted");

    // R12 resident following line suppresses read-ahead
    pulseFlush();
    doRead(32'h1000_3020, 1'b0, 2, 8'd0, "R12 setup");
    doRead(32'h1000_3000, 1'b0, 1, 8'd0, "R12 no duplicate read-ahead");
    doRead(32'h1000_3004, 1'b0, 0, 8'd0, "R12 demand installed");

    // R4 stale until flushed, then refetched
    memGen = 8'd1;
    doRead(32'h1000_3008, 1'b0, 0, 8'd0, "R4 stale kept before flush");
    pulseFlush();
    doRead(32'h1000_3008, 1'b0, 2, 8'd1, "R4 flush discards");

    // R5 address-based invalidate with auto clearing
    regWrite(2'd0, 32'h5);
    cacheOp(1'b1);
    doRead(32'h1000_3008, 1'b0, 2, 8'd1, "R5 auto flush");

    // R6 index-based op, and address-based op with auto clearing off
    cacheOp(1'b0);
    doRead(32'h1000_3008, 1'b0, 0, 8'd1, "R6 index op ignored");
    regWrite(2'd0, 32'h1);
    cacheOp(1'b1);
    doRead(32'h1000_3008, 1'b0, 0, 8'd1, "R6 auto off ignored");

    // R7 instruction-only mode
    regWrite(2'd0, 32'h3);
    pulseFlush();
    doRead(32'h1000_4000, 1'b0, 1, 8'd1, "R7 data bypass");
    doRead(32'h1000_4000, 1'b0, 1, 8'd1, "R7 data not installed");
    doRead(32'h1000_4000, 1'b1, 2, 8'd1, "R7 instr read-ahead");
    doRead(32'h1000_4010, 1'b1, 0, 8'd1, "R7 instr hit");
    doRead(32'h1000_4010, 1'b0, 1, 8'd1, "R7 data bypass when resident");

    // R9 disabled: resident line is not used, no read-ahead
    regWrite(2'd0, 32'h0);
    doRead(32'h1000_4000, 1'b1, 1, 8'd1, "R9 disabled pass-through");
    doRead(32'h1000_3000, 1'b0, 1, 8'd1, "R9 disabled no read-ahead");

    // R10 flush while the read-ahead is outstanding
    regWrite(2'd0, 32'h1);
    pulseFlush();
    fork
      doRead(32'h1000_5000, 1'b0, 2, 8'd1, "R10 setup");
      begin
        do @(negedge clk); while (!(memReqValid && memReqAddr == 32'h1000_5020));
        flushPulse = 1'b1;
        @(negedge clk);
        flushPulse = 1'b0;
      end
    join
    doRead(32'h1000_5020, 1'b0, 2, 8'd1, "R10 killed line not installed");

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule